// File: doc/BRIEF.md
# Multi-Queue Interrupt Status Controller

This block collects event pulses from the transmit and receive engines of a multi-queue Ethernet MAC and turns them into one level interrupt per queue. Each queue has a status register and a mask register. Queue 0 is the main queue. Queues 1 and up are extra queues. An event carries a queue index and a vector of flags. A flag is recorded only where the queue's mask bit is clear. Software changes the mask through a write-only enable port and a write-only disable port. It acknowledges interrupts by reading the status register, and that read clears the status bits.

The register port is a plain 32-bit read/write port that reads combinationally. Each queue takes a group of four words. Queue groups beyond the configured queue count read as zero and ignore writes. Each interrupt line simply follows whether its queue's status register is nonzero.

Top module: `mq_irq_ctrl`

## Requirements
- R1: When an event arrives for a present queue, each flag bit sets the matching status bit only if that queue's mask bit is 0. A masked flag is dropped and does not appear later when the bit is unmasked.
- R2: Writing the enable word clears every mask bit that is written 1, and writing the disable word sets them. Queue 0 accepts all 32 bits. Extra queues accept only the bits in 0x00000CE6, and their other mask bits keep their value.
- R3: Reading queue 0's status word clears all 32 status bits on the next clock. Reading an extra queue's status word clears only the bits in 0x00000CE6.
- R4: The address is reg_addr[4:2] = queue index and reg_addr[1:0] = word. Word 0 is status, 1 is enable, 2 is disable and 3 is mask. Writes to status or mask have no effect, and reads of enable or disable return 0.
- R5: irq[q] is 1 exactly when queue q's status register is nonzero, in the same cycle as the register value.
- R6: Flag bit 1 means receive complete, bit 2 receive buffer used, bit 3 transmit buffer used, bit 6 bus error and bit 7 transmit complete. Bit 3 is recorded only for queue 0 and is ignored on every other queue.
- R7: After reset every status register is 0, the queue 0 mask is 0, and every extra queue's mask is 0x00000CE6.
- R8: Addresses whose queue index is NUM_QUEUES or higher read as 0 and ignore writes. Events whose queue index is NUM_QUEUES or higher change nothing.
- R9: When a status read and an unmasked event hit the same bit in the same cycle, the bit is set after that clock.
- R10: An event in the same cycle as an enable or disable write is filtered by the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event pulse valid this cycle |
| ev_queue | input | 3 | Queue index of the event |
| ev_flags | input | 32 | Event flag vector |
| reg_addr | input | 5 | Register word address |
| reg_rd | input | 1 | Read strobe; a status read clears it |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| irq | output | NUM_QUEUES | Level interrupt per queue |

## Verification
The cases that are hardest to reach from the ports are collisions inside one clock. One is a clear-on-read of a status word that coincides with a new event on the same queue. The other is a mask write that lands together with an event. The bench drives directed cycles that put the strobe and the event on the same edge. It then runs a long random phase in which reads, enable and disable writes, and events on present and absent queues overlap freely. A behavioural reference model checks read data and every interrupt line in every cycle.

// File: rtl/mq_irq_pkg.sv
package mq_irq_pkg;
    localparam int MAX_QUEUES = 8;
    localparam int QIDX_W     = $clog2(MAX_QUEUES);
    localparam int SEL_W      = 2;
    localparam int ADDR_W     = QIDX_W + SEL_W;
    localparam int DATA_W     = 32;

    // bits software may touch on extra queues; all bits on the main queue
    localparam logic [DATA_W-1:0] QUEUE_BITS = 32'h0000_0CE6;
    localparam logic [DATA_W-1:0] MAIN_BITS  = {DATA_W{1'b1}};

    // flag positions
    localparam int EV_RX_DONE = 1;
    localparam int EV_RX_USED = 2;
    localparam int EV_TX_USED = 3;
    localparam int EV_BUS_ERR = 6;
    localparam int EV_TX_DONE = 7;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS  = 2'd0,
        SEL_ENABLE  = 2'd1,
        SEL_DISABLE = 2'd2,
        SEL_MASK    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] mask;
    } bank_state_t;

    typedef struct packed {
        logic rd_status;
        logic wr_enable;
        logic wr_disable;
    } bank_cmd_t;
endpackage

// File: rtl/mq_irq_decode.sv
module mq_irq_decode
    import mq_irq_pkg::*;
#(
    parameter int NUM_QUEUES = 4
) (
    input  logic [ADDR_W-1:0]                reg_addr_i,
    input  logic                             reg_rd_i,
    input  logic                             reg_wr_i,
    output logic [QIDX_W-1:0]                qidx_o,
    output reg_sel_e                         sel_o,
    output logic                             hit_o,
    output bank_cmd_t [NUM_QUEUES-1:0]       cmd_o
);
    assign qidx_o = reg_addr_i[ADDR_W-1:SEL_W];
    assign sel_o  = reg_sel_e'(reg_addr_i[SEL_W-1:0]);
    assign hit_o  = (32'(qidx_o) < NUM_QUEUES);

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_cmd
        logic here;
        assign here = (qidx_o == QIDX_W'(q));
        assign cmd_o[q].rd_status  = here && reg_rd_i && (sel_o == SEL_STATUS);
        assign cmd_o[q].wr_enable  = here && reg_wr_i && (sel_o == SEL_ENABLE);
        assign cmd_o[q].wr_disable = here && reg_wr_i && (sel_o == SEL_DISABLE);
    end
endmodule

// File: rtl/mq_irq_steer.sv
module mq_irq_steer
    import mq_irq_pkg::*;
#(
    parameter int NUM_QUEUES = 4
) (
    input  logic                                 ev_valid_i,
    input  logic [QIDX_W-1:0]                    ev_queue_i,
    input  logic [DATA_W-1:0]                    ev_flags_i,
    output logic [NUM_QUEUES-1:0][DATA_W-1:0]    flags_o
);
    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_route
        // the transmit-buffer-used flag exists only on the main queue
        localparam logic [DATA_W-1:0] ACCEPT =
            (q == 0) ? MAIN_BITS : ~(DATA_W'(1) << EV_TX_USED);
        assign flags_o[q] = (ev_valid_i && ev_queue_i == QIDX_W'(q))
                          ? (ev_flags_i & ACCEPT) : '0;
    end
endmodule

// File: rtl/mq_irq_bank.sv
module mq_irq_bank
    import mq_irq_pkg::*;
#(
    parameter logic [DATA_W-1:0] WR_BITS  = MAIN_BITS,
    parameter logic [DATA_W-1:0] CLR_BITS = MAIN_BITS,
    parameter logic [DATA_W-1:0] RST_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_cmd_t         cmd_i,
    input  logic [DATA_W-1:0] ev_flags_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] status_o,
    output logic [DATA_W-1:0] mask_o
);
    bank_state_t       state_d, state_q;
    logic [DATA_W-1:0] set_bits, clr_bits, wbits;

    always_comb begin
        set_bits = ev_flags_i & ~state_q.mask;          // old mask filters
        clr_bits = cmd_i.rd_status ? CLR_BITS : '0;
        wbits    = wdata_i & WR_BITS;
        state_d.status = (state_q.status & ~clr_bits) | set_bits; // set wins
        state_d.mask   = state_q.mask;
        if (cmd_i.wr_enable) begin
            state_d.mask = state_d.mask & ~wbits;
        end
        if (cmd_i.wr_disable) begin
            state_d.mask = state_d.mask | wbits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{status: '0, mask: RST_MASK};
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;
    assign mask_o   = state_q.mask;

    AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((state_q.status & ~$past(state_q.status) & $past(state_q.mask)) == '0)); // R1
    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.wr_enable |=> ((state_q.mask & $past(wdata_i & WR_BITS)) == '0)); // R2
    AST_DISABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i.wr_disable |=> ((~state_q.mask & $past(wdata_i & WR_BITS)) == '0)); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.rd_status && ev_flags_i == '0) |=> ((state_q.status & CLR_BITS) == '0)); // R3
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_i.rd_status && ev_flags_i == '0) |=> $stable(state_q.status)); // R4
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i.rd_status && (ev_flags_i & ~state_q.mask) != '0)
        |=> ((state_q.status & $past(ev_flags_i & ~state_q.mask)) == $past(ev_flags_i & ~state_q.mask))); // R9
endmodule

// File: rtl/mq_irq_ctrl.sv
module mq_irq_ctrl
    import mq_irq_pkg::*;
#(
    parameter int NUM_QUEUES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [2:0]            ev_queue,
    input  logic [31:0]           ev_flags,
    input  logic [4:0]            reg_addr,
    input  logic                  reg_rd,
    input  logic                  reg_wr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    output logic [NUM_QUEUES-1:0] irq
);
    logic [QIDX_W-1:0]                   qidx;
    reg_sel_e                            sel;
    logic                                hit;
    bank_cmd_t [NUM_QUEUES-1:0]          cmd;
    logic [NUM_QUEUES-1:0][DATA_W-1:0]   flags;
    logic [NUM_QUEUES-1:0][DATA_W-1:0]   status_w;
    logic [NUM_QUEUES-1:0][DATA_W-1:0]   mask_w;

    mq_irq_decode #(.NUM_QUEUES(NUM_QUEUES)) i_decode (
        .reg_addr_i (reg_addr),
        .reg_rd_i   (reg_rd),
        .reg_wr_i   (reg_wr),
        .qidx_o     (qidx),
        .sel_o      (sel),
        .hit_o      (hit),
        .cmd_o      (cmd)
    );

    mq_irq_steer #(.NUM_QUEUES(NUM_QUEUES)) i_steer (
        .ev_valid_i (ev_valid),
        .ev_queue_i (ev_queue),
        .ev_flags_i (ev_flags),
        .flags_o    (flags)
    );

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_bank
        localparam logic [DATA_W-1:0] BK_BITS = (q == 0) ? MAIN_BITS : QUEUE_BITS;
        localparam logic [DATA_W-1:0] BK_RST  = (q == 0) ? '0 : QUEUE_BITS;

        mq_irq_bank #(
            .WR_BITS  (BK_BITS),
            .CLR_BITS (BK_BITS),
            .RST_MASK (BK_RST)
        ) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd_i      (cmd[q]),
            .ev_flags_i (flags[q]),
            .wdata_i    (reg_wdata),
            .status_o   (status_w[q]),
            .mask_o     (mask_w[q])
        );

        assign irq[q] = |status_w[q];

        if (q > 0) begin : g_tx_used_chk
            AST_TXUSED_Q0_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                status_w[q][EV_TX_USED] == 1'b0); // R6
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd && hit) begin
            for (int q = 0; q < NUM_QUEUES; q++) begin
                if (qidx == QIDX_W'(q)) begin
                    case (sel)
                        SEL_STATUS: reg_rdata = status_w[q];
                        SEL_MASK:   reg_rdata = mask_w[q];
                        default:    reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    AST_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !hit) |-> (reg_rdata == '0)); // R8
    AST_WO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (sel == SEL_ENABLE || sel == SEL_DISABLE)) |-> (reg_rdata == '0)); // R4
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == '0 && !(ev_valid && ev_queue == '0)) |=> !irq[0]); // R5
endmodule

// File: tb/test_mq_irq_ctrl.sv
`timescale 1ns/1ps
module test_mq_irq_ctrl;
    localparam int NQ = 4;
    localparam logic [31:0] QB = 32'h0000_0CE6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [2:0]  ev_queue = '0;
    logic [31:0] ev_flags = '0;
    logic [4:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NQ-1:0] irq;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    seen_edge = 0;
    bit    done = 0;
    string tag = "R7 R8";

    logic [31:0] m_st [8];
    logic [31:0] m_mk [8];

    always #4 clk = ~clk;

    mq_irq_ctrl #(.NUM_QUEUES(NQ)) i_mq_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_queue(ev_queue),
        .ev_flags(ev_flags), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] wbits(int q);
        return (q == 0) ? 32'hFFFF_FFFF : QB;
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        seen_edge = 1;
        if (!rst_n) begin
            for (int q = 0; q < 8; q++) begin
                m_st[q] = '0;
                m_mk[q] = (q == 0) ? 32'h0 : QB;
            end
        end else begin
            int aq;
            aq = int'(reg_addr[4:2]);
            if (reg_rd && aq < NQ && reg_addr[1:0] == 2'd0)
                m_st[aq] = m_st[aq] & ~wbits(aq);
            if (ev_valid && int'(ev_queue) < NQ) begin
                logic [31:0] f;
                f = ev_flags;
                if (ev_queue != 3'd0) f[3] = 1'b0;
                m_st[ev_queue] = m_st[ev_queue] | (f & ~m_mk[ev_queue]);
            end
            if (reg_wr && aq < NQ && reg_addr[1:0] == 2'd1)
                m_mk[aq] = m_mk[aq] & ~(reg_wdata & wbits(aq));
            if (reg_wr && aq < NQ && reg_addr[1:0] == 2'd2)
                m_mk[aq] = m_mk[aq] | (reg_wdata & wbits(aq));
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            for (int q = 0; q < NQ; q++) begin
                n_chk++;
                if (irq[q] !== (m_st[q] != 0)) begin
                    n_bad++;
                    $display("FAIL R5 %s irq[%0d] actual=%b expected=%b t=%0t",
                             tag, q, irq[q], (m_st[q] != 0), $time);
                end
            end
            if (reg_rd) begin
                logic [31:0] e;
                int aq;
                aq = int'(reg_addr[4:2]);
                e = '0;
                if (aq < NQ && reg_addr[1:0] == 2'd0) e = m_st[aq];
                if (aq < NQ && reg_addr[1:0] == 2'd3) e = m_mk[aq];
                n_chk++;
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s R4 rdata addr=%0d actual=%h expected=%h t=%0t",
                             tag, reg_addr, reg_rdata, e, $time);
                end
            end
        end
    end

    task automatic step(input bit ev, input int eq, input logic [31:0] ef,
                        input bit rd, input bit wr, input int ad, input logic [31:0] wd);
        @(posedge clk); #2;
        ev_valid = ev; ev_queue = 3'(eq); ev_flags = ef;
        reg_rd = rd; reg_wr = wr; reg_addr = 5'(ad); reg_wdata = wd;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0);
    endtask

    function automatic int adr(int q, int w);
        return q * 4 + w;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R7 R8: reset values over the whole address space
        tag = "R7 R8 reset";
        for (int a = 0; a < 32; a++) step(0, 0, 0, 1, 0, a, 0);
        // R1 R6: receive complete and transmit complete on the main queue
        tag = "R1 R6 main event";
        step(1, 0, 32'h82, 0, 0, 0, 0);
        idle();
        step(0, 0, 0, 1, 0, adr(0, 0), 0);          // R3 read clears
        tag = "R3 main clear";
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        // R2: disable bit 7 on queue 0, event then dropped (R1)
        tag = "R2 R1 mask q0";
        step(0, 0, 0, 0, 1, adr(0, 2), 32'h80);
        step(1, 0, 32'hC0, 1, 0, adr(0, 3), 0);
        step(0, 0, 0, 0, 1, adr(0, 1), 32'h80);      // unmask: no late set
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        // R2: extra queue accepts only writable bits
        tag = "R2 q1 enable";
        step(0, 0, 0, 0, 1, adr(1, 1), 32'hFFFF_FFFF);
        step(0, 0, 0, 1, 0, adr(1, 3), 0);
        step(0, 0, 0, 0, 1, adr(1, 2), 32'hFFFF_FFFF);
        step(0, 0, 0, 1, 0, adr(1, 3), 0);
        step(0, 0, 0, 0, 1, adr(1, 1), 32'hFFFF_FFFF);
        // R6: transmit buffer used ignored on queue 1
        tag = "R6 q1 txused";
        step(1, 1, 32'h0000_000C, 0, 0, 0, 0);
        step(1, 0, 32'h0000_0008, 1, 0, adr(1, 0), 0);
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        // R4: writes to status and mask ignored, write-only words read 0
        tag = "R4 read-only";
        step(1, 2, 32'h0000_0040, 0, 1, adr(0, 0), 32'hFFFF_FFFF);
        step(0, 0, 0, 0, 1, adr(0, 3), 32'hFFFF_FFFF);
        step(0, 0, 0, 1, 0, adr(0, 3), 0);
        step(0, 0, 0, 1, 0, adr(0, 1), 0);
        step(0, 0, 0, 1, 0, adr(1, 2), 0);
        // R8: absent queues
        tag = "R8 absent";
        step(0, 0, 0, 0, 1, adr(5, 1), 32'hFFFF_FFFF);
        step(1, 6, 32'hFFFF_FFFF, 1, 0, adr(5, 3), 0);
        step(0, 0, 0, 1, 0, adr(7, 0), 0);
        // R9: read and event collide on the same bit
        tag = "R9 collide";
        step(1, 0, 32'h2, 0, 0, 0, 0);
        step(1, 0, 32'h2, 1, 0, adr(0, 0), 0);
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        step(1, 1, 32'h4, 0, 0, 0, 0);
        step(1, 1, 32'h4, 1, 0, adr(1, 0), 0);
        step(0, 0, 0, 1, 0, adr(1, 0), 0);
        // R10: mask write in the same cycle as an event
        tag = "R10 mask race";
        step(1, 0, 32'h40, 0, 1, adr(0, 2), 32'h40);  // old mask clear: set
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        step(1, 0, 32'h40, 0, 1, adr(0, 1), 32'h40);  // old mask set: dropped
        step(0, 0, 0, 1, 0, adr(0, 0), 0);
        // random overlap phase
        tag = "R1 R2 R3 R5 random";
        void'($urandom(7));
        for (int i = 0; i < 3000; i++) begin
            int eq;
            logic [31:0] ef;
            eq = int'($urandom_range(0, 7));
            ef = $urandom & ((eq == 0) ? 32'hFFFF_FFFF : 32'h0000_0CEE);
            step($urandom_range(0, 1) == 1, eq, ef,
                 $urandom_range(0, 9) < 4, $urandom_range(0, 9) < 2,
                 int'($urandom_range(0, 31)), $urandom);
        end
        // R3: extra queue read leaves bits outside the writable set
        tag = "R3 q3 partial clear";
        step(0, 0, 0, 0, 1, adr(3, 2), 32'hFFFF_FFFF);
        step(0, 0, 0, 1, 0, adr(3, 0), 0);
        step(1, 3, 32'h0000_0014, 0, 0, 0, 0);
        step(0, 0, 0, 1, 0, adr(3, 0), 0);
        step(0, 0, 0, 1, 0, adr(3, 0), 0);
        idle();
        idle();
        @(posedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog %s actual=hung expected=finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule